// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a synchronous requester read and write an asynchronous 16-bit static RAM. A request is a single transfer. It carries a read/write flag, a word address, write data and one enable bit for each byte lane. It is handed over with a valid/ready handshake. A read returns its 16-bit result together with a one-cycle valid strobe. Toward the memory, the block drives a low-true and a high-true chip select, low-true output-enable and write-enable strobes, and one low-true select for each byte lane. It also drives outgoing data, plus an enable for the pad tristate buffers, and it reads incoming data from the shared bus.

Phase lengths are set in nanoseconds and converted to clock cycles when the design is elaborated. Each value is rounded up, and each phase is at least one cycle. The read access phase covers both address access and output-enable access. The write pulse covers both the minimum pulse width and the data setup time before the write ends. Output enable stays high for the whole of a write. After every read there is a turnaround phase with nothing driven, so the controller never drives the bus while the memory may still be releasing it.

A request with both byte enables clear would put the memory in standby even though it is selected. Such a request is therefore completed without touching the memory.

Top module: `asram_lane_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle. Chip select 1 is high, chip select 2 is low, output enable, write enable and both lane selects are high, the data enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken only in a cycle where `req_ready` is high. `req_ready` stays low from the acceptance of a memory access until the controller is idle again.
- R3: A read keeps chip select 1 low, chip select 2 high and write enable high. It holds output enable low for exactly RD cycles, where RD = max(1, ceil(T_ACC_NS*1000/CLK_PS)).
- R4: Read data is captured in the last cycle with output enable low, and `rsp_valid` is high for exactly one cycle, the one after that cycle. An accepted read therefore responds RD+1 cycles after the accepting edge. Byte-enable bit 0 drives the lower lane select and bus bits 7:0. Bit 1 drives the upper lane select and bits 15:8. A lane that was not enabled reads back as zero.
- R5: A write holds write enable low for exactly WP cycles, where WP = max(1, ceil(T_WP_NS*1000/CLK_PS), ceil(T_DW_NS*1000/CLK_PS)). Throughout that time output enable is high, the data enable is high and the request's write data is on `mem_dq_out`.
- R6: The address and lane selects do not change while write enable is low. In the cycle after write enable returns high, the address, lane selects and chip selects still hold their values.
- R7: The data enable is never high while output enable is low. It also stays low for at least TA cycles after output enable rises, where TA = max(1, ceil(T_HZ_NS*1000/CLK_PS)).
- R8: A request with both byte enables zero is accepted without any memory strobe. Such a write leaves memory unchanged. Such a read gives `rsp_valid` in the cycle after acceptance with data zero.
- R9: A write with one byte enable changes only that lane of the addressed word.
- R10: Output enable and write enable are never low together. Whenever either one is low, the chip is selected and at least one lane select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 2*LANE_W | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low lane |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 2*LANE_W | Read result, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs1_n | output | 1 | Chip select 1, active low |
| mem_cs2 | output | 1 | Chip select 2, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_out | output | 2*LANE_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Tristate enable for `mem_dq_out` |
| mem_dq_in | input | 2*LANE_W | Data from the memory bus |

## Verification
The bench uses ADDR_W = 4, so all sixteen words can be written and read back in every lane pattern. It uses an 8 ns clock with nanosecond values of 20, 9, 17 and 10. These give a three-cycle access, a three-cycle write pulse set by the data setup time rather than the pulse width, and a two-cycle turnaround. The bench computes these counts from the nanosecond values itself. With phases this short, each read is directly followed by writes, so turnaround violations, off-by-one phase lengths and lane mix-ups all show up. A small model of the memory in the bench drives filler on lanes that are not selected.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD      = 3'd1,
    ST_RD_TURN = 3'd2,
    ST_WR      = 3'd3,
    ST_WR_REC  = 3'd4
  } asram_state_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_lane_capture.sv
module asram_lane_capture #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic                    clr,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] q, d;
    logic              en;

    assign en = cap_en || clr;

    always_comb begin
      d = '0;
      if (cap_en && lane_en[g]) begin
        d = dq_in[g*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int CNT_W  = 3,
  parameter int RD_CYC = 6,
  parameter int WP_CYC = 5,
  parameter int TA_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic              timer_done,
  output logic              req_ready,
  output logic              timer_load,
  output logic [CNT_W-1:0]  timer_val,
  output logic              cap_en,
  output logic              null_rd,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              sel,
  output logic              oe,
  output logic              we,
  output logic [LANES-1:0]  lane,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  asram_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [LANES-1:0]  lane_q, lane_d;
  logic              sel_q, sel_d;
  logic              oe_q, oe_d;
  logic              we_q, we_d;
  logic              dqoe_q, dqoe_d;
  logic              rsp_q, rsp_d;
  logic              take;

  assign take = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    wdata_d    = wdata_q;
    lane_d     = lane_q;
    sel_d      = sel_q;
    oe_d       = oe_q;
    we_d       = we_q;
    dqoe_d     = dqoe_q;
    rsp_d      = 1'b0;
    timer_load = 1'b0;
    timer_val  = '0;
    cap_en     = 1'b0;
    null_rd    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (take) begin
          if (req_be == '0) begin
            if (!req_write) begin
              null_rd = 1'b1;
              rsp_d   = 1'b1;
            end
          end else if (req_write) begin
            state_d    = ST_WR;
            addr_d     = req_addr;
            wdata_d    = req_wdata;
            lane_d     = req_be;
            sel_d      = 1'b1;
            we_d       = 1'b1;
            dqoe_d     = 1'b1;
            timer_load = 1'b1;
            timer_val  = CNT_W'(WP_CYC - 1);
          end else begin
            state_d    = ST_RD;
            addr_d     = req_addr;
            lane_d     = req_be;
            sel_d      = 1'b1;
            oe_d       = 1'b1;
            timer_load = 1'b1;
            timer_val  = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD: begin
        if (timer_done) begin
          cap_en     = 1'b1;
          rsp_d      = 1'b1;
          oe_d       = 1'b0;
          sel_d      = 1'b0;
          lane_d     = '0;
          state_d    = ST_RD_TURN;
          timer_load = 1'b1;
          timer_val  = CNT_W'(TA_CYC - 1);
        end
      end
      ST_RD_TURN: begin
        if (timer_done) begin
          state_d = ST_IDLE;
        end
      end
      ST_WR: begin
        if (timer_done) begin
          we_d    = 1'b0;
          state_d = ST_WR_REC;
        end
      end
      ST_WR_REC: begin
        sel_d   = 1'b0;
        lane_d  = '0;
        dqoe_d  = 1'b0;
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        sel_d   = 1'b0;
        oe_d    = 1'b0;
        we_d    = 1'b0;
        lane_d  = '0;
        dqoe_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      lane_q  <= '0;
      sel_q   <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      dqoe_q  <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      lane_q  <= lane_d;
      sel_q   <= sel_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      dqoe_q  <= dqoe_d;
      rsp_q   <= rsp_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_q;
  assign mem_addr  = addr_q;
  assign sel       = sel_q;
  assign oe        = oe_q;
  assign we        = we_q;
  assign lane      = lane_q;
  assign dq_out    = wdata_q;
  assign dq_oe     = dqoe_q;

endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int LANE_W   = 8,
  parameter int CLK_PS   = 8000,
  parameter int T_ACC_NS = 45,
  parameter int T_WP_NS  = 35,
  parameter int T_DW_NS  = 25,
  parameter int T_HZ_NS  = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_be,
  output logic                rsp_valid,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_cs1_n,
  output logic                mem_cs2,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [2*LANE_W-1:0] mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [2*LANE_W-1:0] mem_dq_in
);

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;
  localparam int RD_CYC = ns_to_cyc(T_ACC_NS, CLK_PS);
  localparam int WP_CYC = max2(ns_to_cyc(T_WP_NS, CLK_PS), ns_to_cyc(T_DW_NS, CLK_PS));
  localparam int TA_CYC = ns_to_cyc(T_HZ_NS, CLK_PS);
  localparam int MAX_CYC = max2(RD_CYC, max2(WP_CYC, TA_CYC));
  localparam int CNT_W  = $clog2(MAX_CYC + 1);

  logic             timer_load, timer_done;
  logic [CNT_W-1:0] timer_val;
  logic             cap_en, null_rd;
  logic             sel, oe, we;
  logic [LANES-1:0] lane;

  asram_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .TA_CYC (TA_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .timer_done (timer_done),
    .req_ready  (req_ready),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .cap_en     (cap_en),
    .null_rd    (null_rd),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .sel        (sel),
    .oe         (oe),
    .we         (we),
    .lane       (lane),
    .dq_out     (mem_dq_out),
    .dq_oe      (mem_dq_oe)
  );

  asram_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .done     (timer_done)
  );

  asram_lane_capture #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .clr     (null_rd),
    .lane_en (lane),
    .dq_in   (mem_dq_in),
    .rdata   (rsp_rdata)
  );

  assign mem_cs1_n = ~sel;
  assign mem_cs2   = sel;
  assign mem_oe_n  = ~oe;
  assign mem_we_n  = ~we;
  assign mem_lb_n  = ~lane[0];
  assign mem_ub_n  = ~lane[1];

endmodule

// File: rtl/asram_lane_ctrl_chk.sv
module asram_lane_ctrl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs1_n,
  input logic              mem_cs2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe)); // R1

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !req_ready); // R2

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4

  AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && mem_oe_n)); // R5

  AST_WR_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n))); // R6

  AST_WR_RECOVERY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n) && !mem_cs1_n && mem_cs2)); // R6

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R7

  AST_TURN_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> !mem_dq_oe); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R10

  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (!mem_cs1_n && mem_cs2 && !(mem_lb_n && mem_ub_n))); // R10

endmodule

bind asram_lane_ctrl asram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs1_n (mem_cs1_n),
  .mem_cs2   (mem_cs2),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_lb_n  (mem_lb_n),
  .mem_ub_n  (mem_ub_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_asram_lane_ctrl.sv
module tb_asram_lane_ctrl;

  localparam int AW       = 4;
  localparam int LW       = 8;
  localparam int CLK_PS   = 8000;
  localparam int T_ACC_NS = 20;
  localparam int T_WP_NS  = 9;
  localparam int T_DW_NS  = 17;
  localparam int T_HZ_NS  = 10;
  localparam int WORDS    = 1 << AW;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD = cyc(T_ACC_NS);
  localparam int WP = (cyc(T_WP_NS) > cyc(T_DW_NS)) ? cyc(T_WP_NS) : cyc(T_DW_NS);
  localparam int TA = cyc(T_HZ_NS);

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic [1:0]    req_be;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0]   mem_dq_out, mem_dq_in;
  logic          mem_dq_oe;

  int checks = 0;
  int bad = 0;
  logic [15:0] mem_arr [WORDS];

  asram_lane_ctrl #(
    .ADDR_W(AW), .LANE_W(LW), .CLK_PS(CLK_PS), .T_ACC_NS(T_ACC_NS),
    .T_WP_NS(T_WP_NS), .T_DW_NS(T_DW_NS), .T_HZ_NS(T_HZ_NS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #4ns clk = ~clk;

  logic chip_sel;
  assign chip_sel = !mem_cs1_n && mem_cs2;
  assign mem_dq_in = (chip_sel && !mem_oe_n && mem_we_n) ?
    {mem_ub_n ? 8'hA5 : mem_arr[mem_addr][15:8], mem_lb_n ? 8'h5A : mem_arr[mem_addr][7:0]} : 16'hC3C3;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat_f(input int a);
    logic [7:0] hi, lo;
    hi = 8'(a * 17 + 3);
    lo = 8'(a * 29 + 7);
    return {hi, lo};
  endfunction

  // monitor state
  int we_run = 0, oe_run = 0, oe_hi = 100;
  int wr_pulses = 0, rd_pulses = 0;
  logic prev_we_n = 1'b1, prev_rsp = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [1:0] prev_lanes = 2'b11;
  logic [15:0] cur_wdata = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) begin
        we_run++;
        chk("R5 drive during write", {mem_dq_oe, mem_oe_n, mem_dq_out}, {1'b1, 1'b1, cur_wdata});
        if (!prev_we_n)
          chk("R6 addr/lanes stable in pulse", {prev_addr, prev_lanes}, {mem_addr, mem_lb_n, mem_ub_n});
        if (chip_sel) begin
          if (!mem_lb_n) mem_arr[mem_addr][7:0]  = mem_dq_out[7:0];
          if (!mem_ub_n) mem_arr[mem_addr][15:8] = mem_dq_out[15:8];
        end
      end else if (we_run > 0) begin
        chk("R5 write pulse length", we_run, WP);
        chk("R6 hold after write", {chip_sel, prev_addr, prev_lanes}, {1'b1, mem_addr, mem_lb_n, mem_ub_n});
        wr_pulses++;
        we_run = 0;
      end
      if (!mem_oe_n) begin
        oe_run++;
        oe_hi = 0;
        chk("R3 read strobes", {chip_sel, mem_we_n}, 2'b11);
      end else begin
        if (oe_run > 0) begin
          chk("R3 oe low length", oe_run, RD);
          rd_pulses++;
          oe_run = 0;
        end
        oe_hi++;
      end
      if (mem_dq_oe) chk("R7 turnaround", (!mem_oe_n || oe_hi <= TA) ? 1 : 0, 0);
      if (!mem_oe_n || !mem_we_n)
        chk("R10 strobe legality", {(!mem_oe_n && !mem_we_n), chip_sel, (mem_lb_n && mem_ub_n), req_ready}, 4'b0100);
      if (rsp_valid) chk("R4 single-cycle rsp", prev_rsp, 0);
      prev_rsp = rsp_valid;
      prev_we_n = mem_we_n;
      prev_addr = mem_addr;
      prev_lanes = {mem_lb_n, mem_ub_n};
    end
  end

  task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d; req_be = be;
    cur_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_read(input int a, input logic [1:0] be, output logic [15:0] d, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); req_wdata = 16'h0; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    d = rsp_rdata;
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [15:0] d, e;
    int lat, wp0, rp0;
    rst_n = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    #1ns rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid},
        9'b101111010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid},
        9'b101111010);

    for (int a = 0; a < WORDS; a++) do_write(a, pat_f(a), 2'b11);
    for (int a = 0; a < WORDS; a++) begin
      for (int b = 1; b < 4; b++) begin
        do_read(a, 2'(b), d, lat);
        e = pat_f(a);
        if (b == 1) e[15:8] = 8'h00;
        if (b == 2) e[7:0] = 8'h00;
        chk("R4 read data by lane", d, e);
        chk("R4 read latency", lat, RD + 1);
      end
    end

    for (int a = 0; a < WORDS; a++) do_write(a, ~pat_f(a), (a % 2 == 1) ? 2'b01 : 2'b10);
    for (int a = 0; a < WORDS; a++) begin
      do_read(a, 2'b11, d, lat);
      e = pat_f(a);
      if (a % 2 == 1) e[7:0] = ~e[7:0]; else e[15:8] = ~e[15:8];
      chk("R9 partial write merge", d, e);
    end

    wp0 = wr_pulses;
    do_write(5, 16'hFFFF, 2'b00);
    repeat (2) @(negedge clk);
    chk("R8 null write no pulse", wr_pulses, wp0);
    do_read(5, 2'b11, d, lat);
    e = pat_f(5); e[7:0] = ~e[7:0];
    chk("R8 null write no effect", d, e);
    rp0 = rd_pulses;
    do_read(5, 2'b00, d, lat);
    chk("R8 null read data", d, 0);
    chk("R8 null read latency", lat, 1);
    chk("R8 null read no strobe", rd_pulses, rp0);

    do_write(3, 16'h1234, 2'b11);
    do_read(3, 2'b11, d, lat);
    chk("R2 back-to-back", d, 16'h1234);
    repeat (4) @(negedge clk);
    chk("R2 idle ready", req_ready, 1);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule